// File: doc/BRIEF.md
# Dual-Chain Carry-Select Arithmetic Cluster

This block is a row of identical bit slices that together form an adder/subtractor, an up/down counter or, with its registered output fed back into its first operand, an accumulator. Each slice works out two candidate sum bits ahead of time, one for an incoming carry of 0 and one for an incoming carry of 1. It also works out two candidate carry-outs. Two carry chains run side by side through the row. Chain 0 starts at the least significant slice with a carry of 0, and chain 1 starts there with a carry of 1. The effective cluster carry-in arrives late and only picks a chain. The carry level of the chosen chain at each slice then picks that slice's sum bit.

Every slice gives its selected sum both as a combinational output and through a result register. One set of controls acts on the whole cluster: add or subtract, clock enable, counter enable, count direction, synchronous clear and synchronous load. The operands are plain level inputs, looked at in every cycle. Nothing is handed over by a handshake, so there is no valid/ready pairing and no back-pressure. The register takes its next value in every cycle in which the clock enable is high.

Top module: `dual_chain_arith_cluster`

## Requirements
- R1: With `cnt_en`=0 and `sub_mode`=0, `comb_sum` = (`opa` + `opb` + `cin`) mod 2^WIDTH and `cout` is bit WIDTH of that sum.
- R2: With `cnt_en`=0 and `sub_mode`=1, `comb_sum` = (`opa` - `opb` - `cin`) mod 2^WIDTH. `cout` is 1 exactly when `opa` >= `opb` + `cin` (no borrow), because the cluster forms `opa` + ~`opb` + (1 - `cin`).
- R3: With `cnt_en`=1 and `count_down`=0, the slices form `reg_sum` + 1. `cout` is 1 only when `reg_sum` is all ones, and `cin`, `opa`, `opb` and `sub_mode` have no effect on `comb_sum` or `cout`.
- R4: With `cnt_en`=1 and `count_down`=1, the slices form `reg_sum` - 1, by adding all ones with a carry-in of 0. `cout` is 0 only when `reg_sum` is 0, and `cin` has no effect.
- R5: At a clock edge with `clk_en`=1 and `sync_clr`=1, `reg_sum` becomes 0, whatever `sync_ld` and `cnt_en` are.
- R6: At a clock edge with `clk_en`=1, `sync_clr`=0 and `sync_ld`=1, `reg_sum` becomes `load_val`, even when counting is enabled.
- R7: At a clock edge with `clk_en`=0, `reg_sum` keeps its value whatever the other controls are.
- R8: At a clock edge with `clk_en`=1 and neither clear nor load, `reg_sum` takes the `comb_sum` present before that edge. This is the add or subtract result when `cnt_en`=0, and the next count when `cnt_en`=1.
- R9: While `rst_n` is low, `reg_sum` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| load_val | input | WIDTH | Value taken by a synchronous load |
| cin | input | 1 | Cluster carry-in (acts as borrow-in when subtracting) |
| sub_mode | input | 1 | 1 = subtract `opb`, 0 = add it |
| clk_en | input | 1 | Enables any change of the result register |
| cnt_en | input | 1 | Selects counter operation on the registered value |
| count_down | input | 1 | Count direction: 1 = down, 0 = up |
| sync_clr | input | 1 | Synchronous clear, highest priority |
| sync_ld | input | 1 | Synchronous load of `load_val` |
| comb_sum | output | WIDTH | Unregistered selected sum |
| reg_sum | output | WIDTH | Registered sum |
| cout | output | 1 | Carry-out of the selected chain at the top slice |

## Verification
The hardest cases to reach are the ones where the two chains disagree over a long run of propagate bits, because only then does the late choice of chain decide the result. The top carry-out also depends on the choice there. A 4-bit cluster lets the bench sweep every operand pair with both carry-in values, in both add and subtract mode, so every run of propagating slices is covered. The counter wrap points, all ones going up and zero going down, are reached by loading a value next to the boundary and then counting across it, with `cin` toggled to show that it has no effect.

// File: rtl/cluster_pkg.sv
package cluster_pkg;
  // Carry-out of one bit position for a given incoming carry.
  function automatic logic slice_carry(input logic a, input logic b, input logic ci);
    return ci ? (a | b) : (a & b);
  endfunction
endpackage

// File: rtl/arith_opsel.sv
module arith_opsel #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] reg_q,
  input  logic             cin,
  input  logic             sub_mode,
  input  logic             cnt_en,
  input  logic             count_down,
  output logic [WIDTH-1:0] a_eff,
  output logic [WIDTH-1:0] b_eff,
  output logic             eff_cin
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  always_comb begin
    if (cnt_en) begin
      // counter: up adds 0 with carry 1, down adds all ones with carry 0
      a_eff   = reg_q;
      b_eff   = count_down ? ALL_ONES : '0;
      eff_cin = ~count_down;
    end else if (sub_mode) begin
      a_eff   = opa;
      b_eff   = ~opb;
      eff_cin = ~cin;
    end else begin
      a_eff   = opa;
      b_eff   = opb;
      eff_cin = cin;
    end
  end
endmodule

// File: rtl/arith_slice.sv
module arith_slice
  import cluster_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci0,
  input  logic ci1,
  output logic s0,
  output logic s1,
  output logic co0,
  output logic co1
);
  // Candidate sums for an incoming carry of 0 and of 1.
  assign s0  = a ^ b;
  assign s1  = ~(a ^ b);
  // Each chain's own carry picks its own carry-out.
  assign co0 = slice_carry(a, b, ci0);
  assign co1 = slice_carry(a, b, ci1);
endmodule

// File: rtl/result_reg.sv
module result_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             sync_clr,
  input  logic             sync_ld,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] next_val,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clk_en) begin
      if (sync_clr)      q <= '0;
      else if (sync_ld)  q <= load_val;
      else               q <= next_val;
    end
  end

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sync_clr) |=> (q == '0));
  a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sync_clr && sync_ld) |=> (q == $past(load_val)));
  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(q));
endmodule

// File: rtl/dual_chain_arith_cluster.sv
module dual_chain_arith_cluster #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] load_val,
  input  logic             cin,
  input  logic             sub_mode,
  input  logic             clk_en,
  input  logic             cnt_en,
  input  logic             count_down,
  input  logic             sync_clr,
  input  logic             sync_ld,
  output logic [WIDTH-1:0] comb_sum,
  output logic [WIDTH-1:0] reg_sum,
  output logic             cout
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] a_eff, b_eff;
  logic             eff_cin;
  logic [WIDTH:0]   chain0, chain1;
  logic [WIDTH-1:0] cand0, cand1, pick;

  arith_opsel #(.WIDTH(WIDTH)) u_opsel (
    .opa(opa), .opb(opb), .reg_q(reg_sum), .cin(cin), .sub_mode(sub_mode),
    .cnt_en(cnt_en), .count_down(count_down),
    .a_eff(a_eff), .b_eff(b_eff), .eff_cin(eff_cin)
  );

  // The chains are seeded with a fixed carry at the least significant slice.
  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    arith_slice u_slice (
      .a(a_eff[i]), .b(b_eff[i]), .ci0(chain0[i]), .ci1(chain1[i]),
      .s0(cand0[i]), .s1(cand1[i]), .co0(chain0[i+1]), .co1(chain1[i+1])
    );
    // Late choice of chain, then that chain's carry picks the sum bit.
    assign pick[i]     = eff_cin ? chain1[i] : chain0[i];
    assign comb_sum[i] = pick[i] ? cand1[i] : cand0[i];

    // R1: a carry on chain 0 always means a carry on chain 1 as well
    a_r1_chain_order: assert property (@(posedge clk) disable iff (!rst_n)
      chain0[i+1] |-> chain1[i+1]);
  end

  assign cout = eff_cin ? chain1[WIDTH] : chain0[WIDTH];

  result_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sync_clr(sync_clr),
    .sync_ld(sync_ld), .load_val(load_val), .next_val(comb_sum), .q(reg_sum)
  );

  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sync_clr && !sync_ld && cnt_en && !count_down)
    |=> (reg_sum == WIDTH'($past(reg_sum) + 1'b1)));
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sync_clr && !sync_ld && cnt_en && count_down)
    |=> (reg_sum == WIDTH'($past(reg_sum) - 1'b1)));
  a_r3_up_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !count_down) |-> (cout == (reg_sum == ALL_ONES)));
endmodule

// File: tb/dual_chain_arith_cluster_bench.sv
module dual_chain_arith_cluster_bench;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] opa = '0, opb = '0, load_val = '0;
  logic cin = 0, sub_mode = 0, clk_en = 0, cnt_en = 0, count_down = 0;
  logic sync_clr = 0, sync_ld = 0;
  logic [W-1:0] comb_sum, reg_sum;
  logic cout;

  int checks = 0, errors = 0;
  int model;

  dual_chain_arith_cluster #(.WIDTH(W)) u_dual_chain_arith_cluster (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .load_val(load_val),
    .cin(cin), .sub_mode(sub_mode), .clk_en(clk_en), .cnt_en(cnt_en),
    .count_down(count_down), .sync_clr(sync_clr), .sync_ld(sync_ld),
    .comb_sum(comb_sum), .reg_sum(reg_sum), .cout(cout)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ctl(input logic ce, input logic ce_cnt, input logic dn,
                     input logic clr, input logic ld);
    clk_en = ce; cnt_en = ce_cnt; count_down = dn; sync_clr = clr; sync_ld = ld;
  endtask

  initial begin
    @(negedge clk);
    chk("R9 reset reg", reg_sum, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release", reg_sum, 0);

    // R1 R2 R8: exhaustive add and subtract sweep, combinational then registered
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          for (int c = 0; c < 2; c++) begin
            int full;
            opa = W'(a); opb = W'(b); cin = c[0]; sub_mode = s[0];
            ctl(1, 0, 0, 0, 0);
            if (s == 0) full = a + b + c;
            else        full = a + ((~b) & (M - 1)) + (1 - c);
            #1;
            chk(s == 0 ? "R1 sum" : "R2 diff", comb_sum, full % M);
            chk(s == 0 ? "R1 cout" : "R2 no-borrow", cout, (full / M) % 2);
            @(negedge clk);
            chk("R8 capture", reg_sum, full % M);
          end

    // R6 load overrides counting
    load_val = W'(M - 2); ctl(1, 1, 0, 0, 1);
    @(negedge clk);
    chk("R6 load over count", reg_sum, M - 2);
    model = M - 2;

    // R3 count up across the wrap, cin/operands toggled
    for (int k = 0; k < 5; k++) begin
      ctl(1, 1, 0, 0, 0);
      cin = k[0]; opa = W'(k * 3); opb = W'(k * 5); sub_mode = k[1];
      #1;
      chk("R3 comb up", comb_sum, (model + 1) % M);
      chk("R3 up carry", cout, model == M - 1 ? 1 : 0);
      @(negedge clk);
      model = (model + 1) % M;
      chk("R3 reg up", reg_sum, model);
    end

    // R4 count down across zero
    load_val = W'(1); ctl(1, 0, 0, 0, 1);
    @(negedge clk);
    model = 1;
    for (int k = 0; k < 4; k++) begin
      ctl(1, 1, 1, 0, 0);
      cin = ~k[0];
      #1;
      chk("R4 comb down", comb_sum, (model + M - 1) % M);
      chk("R4 down carry", cout, model == 0 ? 0 : 1);
      @(negedge clk);
      model = (model + M - 1) % M;
      chk("R4 reg down", reg_sum, model);
    end

    // R7 clock enable low blocks clear, load and count
    load_val = W'(3);
    ctl(0, 1, 0, 1, 1);
    @(negedge clk);
    chk("R7 hold", reg_sum, model);
    ctl(0, 0, 0, 0, 0); opa = W'(9); opb = W'(2);
    @(negedge clk);
    chk("R7 hold capture", reg_sum, model);

    // R5 clear beats load and count
    ctl(1, 1, 0, 1, 1);
    @(negedge clk);
    chk("R5 clear", reg_sum, 0);

    // R9 asynchronous reset mid-run
    load_val = W'(7); ctl(1, 0, 0, 0, 1);
    @(negedge clk);
    chk("R6 load", reg_sum, 7);
    rst_n = 1'b0; #1;
    chk("R9 async reset", reg_sum, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule